// File: doc/BRIEF.md
# PHY Discovery and Configuration Sequencer

This block walks the management address space of an Ethernet station, one address at a time, through an external MDIO master. It reads each address's status register and decides from the status bits whether a transceiver is present. Each transceiver it accepts is added to a small address table. The block then reads that transceiver's control and advertisement registers and writes back corrected values. It leaves the serial bit timing to the master. It only issues single-register read and write requests and waits for the master's acknowledge.

A scan starts on a one-cycle `start` pulse. The scan takes its settings at that pulse:

- automatic or forced media;
- a full-duplex flag and a 100 Mb/s flag;
- an optional preset advertisement value, where zero means none.

When the scan ends, the block raises `done` and presents the table and its entry count. If no transceiver answered, table entry 0 holds address 1 and `no_phy_warn` is raised. The block keeps one advertisement value per table slot across scans, so a later scan can reuse what an earlier scan settled on.

Top module: `phy_scan_seq`

## Requirements
- R1: Loop indices run 1 to 32 in order. The probed address is the index modulo 32, so address 0 comes last. The scan stops as soon as the table holds MAX_PHYS entries, and no later address is read.
- R2: An address counts as a transceiver when (status & 0x8301) == 0x8001. It also counts when status bit 9 is 0 and any of status bits 14:11 is 1. Other addresses get no further reads.
- R3: For each accepted transceiver, the block reads register 0 (control) and register 4 (advertisement). It records the address in the next table slot, so entry i sits at `phy_table[5*i +: 5]`.
- R4: When advertisement bits 8:5 are all 0, the working advertisement is built as ((status >> 6) & 0x3E0) | 1. Otherwise the working advertisement is the value read.
- R5: The advertisement to program is chosen in this order:
  1. a nonzero preset;
  2. a nonzero value held for the slot;
  3. the working value.
  When neither a preset nor a slot value exists, the working value becomes the shared value for every later transceiver in the scan. Register 4 is written only when the chosen value differs from the working value.
- R6: In automatic mode, control bit 12 is set. If that changed the register, bit 9 (restart) is also set. In forced mode, bit 12 is cleared.
- R7: Control bits 15, 14, 13, 11, 10, 8 and 7 are cleared. Bit 8 is then set from the full-duplex flag and bit 13 from the 100 Mb/s flag.
- R8: Register 0 is written only when the new value differs from the value read. If bit 12 toggled, the same value is written twice, with at least GAP_CYC = CLK_HZ/100000 clock cycles (10 µs) between the two acknowledges.
- R9: A scan that finds nothing leaves `phy_count` = 0, loads 1 into table entry 0 and raises `no_phy_warn`.
- R10: A request to the master is held stable until it is acknowledged. `done` rises at the end of the scan and stays high with no request pending until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a scan |
| forced_mode | input | 1 | 1 = forced media, 0 = automatic negotiation |
| force_fd | input | 1 | Full-duplex flag for the control register |
| force_100 | input | 1 | 100 Mb/s flag for the control register |
| preset_adv | input | 16 | Preset advertisement, 0 = none |
| mdio_req | output | 1 | Request to the MDIO master |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | Target transceiver address |
| mdio_reg | output | 5 | Target register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion from the master |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |
| phy_table | output | 5*MAX_PHYS | Found addresses, entry i at bits 5*i+4:5*i |
| phy_count | output | $clog2(MAX_PHYS+1) | Number of table entries |
| done | output | 1 | Scan complete |
| no_phy_warn | output | 1 | No transceiver found in the last scan |

## Verification
The bench builds the block with MAX_PHYS = 4 and CLK_HZ = 1 MHz. With only four slots, a scan that contains five transceivers hits the early-stop point, and the bench can confirm that the fifth address is never probed. The 1 MHz setting shrinks the 10 µs spacing to 10 cycles, so the measured gap between the double control writes can be checked exactly against its bound. A bus model behind the master port counts reads and writes per address, which exposes every write the block skips.

// File: rtl/phy_scan_seq.sv
module phy_scan_seq #(
  parameter int MAX_PHYS = 4,
  parameter int CLK_HZ   = 100_000_000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic                            forced_mode,
  input  logic                            force_fd,
  input  logic                            force_100,
  input  logic [15:0]                     preset_adv,
  output logic                            mdio_req,
  output logic                            mdio_wr,
  output logic [4:0]                      mdio_phy,
  output logic [4:0]                      mdio_reg,
  output logic [15:0]                     mdio_wdata,
  input  logic                            mdio_ack,
  input  logic [15:0]                     mdio_rdata,
  output logic [5*MAX_PHYS-1:0]           phy_table,
  output logic [$clog2(MAX_PHYS+1)-1:0]   phy_count,
  output logic                            done,
  output logic                            no_phy_warn
);
  localparam int CW      = $clog2(MAX_PHYS+1);
  localparam int SW      = (MAX_PHYS > 1) ? $clog2(MAX_PHYS) : 1;
  localparam int GAP_CYC = (CLK_HZ / 100_000 > 0) ? CLK_HZ / 100_000 : 1;
  localparam int GW      = $clog2(GAP_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ST, S_RD_CT, S_RD_AD, S_PICK, S_WR_AD,
    S_CTRL, S_WR_C1, S_GAP, S_WR_C2, S_NEXT, S_FIN
  } state_t;

  state_t        st;
  logic [5:0]    idx;
  logic [CW-1:0] cnt;
  logic [4:0]    tbl [MAX_PHYS];
  logic [15:0]   slot_adv [MAX_PHYS];
  logic [15:0]   glob_adv, to_adv, adv_have, stat_rd, ctl_rd, ctl_new;
  logic          cfg_forced, cfg_fd, cfg_100;
  logic [GW-1:0] gap;

  wire [SW-1:0] slot   = cnt[SW-1:0];
  wire          accept = ((mdio_rdata & 16'h8301) == 16'h8001) ||
                         (!mdio_rdata[9] && (|mdio_rdata[14:11]));
  wire [15:0]   built  = ((stat_rd >> 6) & 16'h03E0) | 16'h0001;

  wire [15:0] pick_val = (glob_adv != 16'h0) ? glob_adv :
                         (slot_adv[slot] != 16'h0) ? slot_adv[slot] : adv_have;

  wire [15:0] an_val  = cfg_forced ? (ctl_rd & ~16'h1000) : (ctl_rd | 16'h1000);
  wire        ane_chg = an_val != ctl_rd;
  wire [15:0] ctl_calc = ((an_val | ((!cfg_forced && ane_chg) ? 16'h0200 : 16'h0)) & ~16'hED80)
                         | (cfg_fd ? 16'h0100 : 16'h0) | (cfg_100 ? 16'h2000 : 16'h0);

  assign mdio_req   = st inside {S_RD_ST, S_RD_CT, S_RD_AD, S_WR_AD, S_WR_C1, S_WR_C2};
  assign mdio_wr    = st inside {S_WR_AD, S_WR_C1, S_WR_C2};
  assign mdio_phy   = idx[4:0];
  assign mdio_reg   = (st == S_RD_ST) ? 5'd1 : (st inside {S_RD_AD, S_WR_AD}) ? 5'd4 : 5'd0;
  assign mdio_wdata = (st == S_WR_AD) ? to_adv : ctl_new;
  assign phy_count  = cnt;

  for (genvar i = 0; i < MAX_PHYS; i++) begin : g_tbl
    assign phy_table[5*i +: 5] = tbl[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0; done <= 1'b0; no_phy_warn <= 1'b0;
      glob_adv <= '0; to_adv <= '0; adv_have <= '0; stat_rd <= '0;
      ctl_rd <= '0; ctl_new <= '0; gap <= '0;
      cfg_forced <= 1'b0; cfg_fd <= 1'b0; cfg_100 <= 1'b0;
      for (int i = 0; i < MAX_PHYS; i++) begin
        tbl[i] <= '0;
        slot_adv[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          idx <= 6'd1; cnt <= '0; done <= 1'b0; no_phy_warn <= 1'b0;
          cfg_forced <= forced_mode; cfg_fd <= force_fd; cfg_100 <= force_100;
          glob_adv <= preset_adv;
          for (int i = 0; i < MAX_PHYS; i++) tbl[i] <= '0;
          st <= S_RD_ST;
        end
        S_RD_ST: if (mdio_ack) begin
          stat_rd <= mdio_rdata;
          st <= accept ? S_RD_CT : S_NEXT;
        end
        S_RD_CT: if (mdio_ack) begin
          ctl_rd <= mdio_rdata;
          st <= S_RD_AD;
        end
        S_RD_AD: if (mdio_ack) begin
          adv_have <= ((mdio_rdata & 16'h01E0) == 16'h0) ? built : mdio_rdata;
          st <= S_PICK;
        end
        S_PICK: begin
          to_adv <= pick_val;
          if (glob_adv != 16'h0) slot_adv[slot] <= glob_adv;
          else if (slot_adv[slot] == 16'h0) begin
            slot_adv[slot] <= adv_have;
            glob_adv <= adv_have;
          end
          tbl[slot] <= idx[4:0];
          cnt <= cnt + 1'b1;
          st <= (pick_val != adv_have) ? S_WR_AD : S_CTRL;
        end
        S_WR_AD: if (mdio_ack) st <= S_CTRL;
        S_CTRL: begin
          ctl_new <= ctl_calc;
          if (ctl_calc == ctl_rd) st <= S_NEXT;
          else st <= ane_chg ? S_WR_C1 : S_WR_C2;
        end
        S_WR_C1: if (mdio_ack) begin
          gap <= GW'(GAP_CYC - 1);
          st <= S_GAP;
        end
        S_GAP: begin
          if (gap == '0) st <= S_WR_C2;
          else gap <= gap - 1'b1;
        end
        S_WR_C2: if (mdio_ack) st <= S_NEXT;
        S_NEXT: begin
          if (idx == 6'd32 || cnt == CW'(MAX_PHYS)) st <= S_FIN;
          else begin
            idx <= idx + 1'b1;
            st <= S_RD_ST;
          end
        end
        S_FIN: begin
          if (cnt == '0) begin
            tbl[0] <= 5'd1;
            no_phy_warn <= 1'b1;
          end
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phy_count <= CW'(MAX_PHYS));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=> (mdio_req && $stable({mdio_wr, mdio_phy, mdio_reg, mdio_wdata})));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdio_req);

  assert_ctrl_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_wr && mdio_reg == 5'd0) |->
      ((mdio_wdata & 16'hCC80) == 16'h0 && mdio_wdata[8] == cfg_fd && mdio_wdata[13] == cfg_100));

  assert_gap_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR_C2 && $past(st) == S_GAP) |-> ($past(gap) == '0));

  assert_warn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    no_phy_warn |-> (phy_count == '0 && phy_table[4:0] == 5'd1));
endmodule

// File: tb/test_phy_scan_seq.sv
module test_phy_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 4;
  localparam int CHZ  = 1_000_000;
  localparam int GAPC = CHZ / 100_000;

  logic clk = 0, rst_n = 0, start = 0, forced_mode = 0, force_fd = 0, force_100 = 0;
  logic [15:0] preset_adv = 0;
  logic mdio_req, mdio_wr, mdio_ack = 0;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata, mdio_rdata = 0;
  logic [5*MAXP-1:0] phy_table;
  logic [2:0] phy_count;
  logic done, no_phy_warn;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] m_st [32], m_ct [32], m_ad [32];
  int rd_st [32], rd_ct [32], wr_ct [32], wr_ad [32], ct_last [32], ct_gap [32];

  phy_scan_seq #(.MAX_PHYS(MAXP), .CLK_HZ(CHZ)) i_phy_scan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .forced_mode(forced_mode),
    .force_fd(force_fd), .force_100(force_100), .preset_adv(preset_adv),
    .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
    .phy_table(phy_table), .phy_count(phy_count), .done(done), .no_phy_warn(no_phy_warn));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always begin
    @(negedge clk);
    if (mdio_req) begin
      repeat (2) @(negedge clk);
      if (mdio_wr) begin
        if (mdio_reg == 5'd0) begin
          if (wr_ct[mdio_phy] > 0) ct_gap[mdio_phy] = cyc - ct_last[mdio_phy];
          ct_last[mdio_phy] = cyc;
          wr_ct[mdio_phy]++;
          m_ct[mdio_phy] = mdio_wdata;
        end else if (mdio_reg == 5'd4) begin
          wr_ad[mdio_phy]++;
          m_ad[mdio_phy] = mdio_wdata;
        end
      end else begin
        case (mdio_reg)
          5'd1: begin mdio_rdata = m_st[mdio_phy]; rd_st[mdio_phy]++; end
          5'd0: begin mdio_rdata = m_ct[mdio_phy]; rd_ct[mdio_phy]++; end
          5'd4: mdio_rdata = m_ad[mdio_phy];
          default: mdio_rdata = 16'h0;
        endcase
      end
      mdio_ack = 1;
      @(negedge clk);
      mdio_ack = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int a = 0; a < 32; a++) begin
      m_st[a] = 16'hFFFF; m_ct[a] = 0; m_ad[a] = 0;
      rd_st[a] = 0; rd_ct[a] = 0; wr_ct[a] = 0; wr_ad[a] = 0; ct_last[a] = 0; ct_gap[a] = 0;
    end
  endtask

  task automatic run_scan(input logic fm, input logic fd, input logic f1, input logic [15:0] pre);
    @(negedge clk);
    forced_mode = fm; force_fd = fd; force_100 = f1; preset_adv = pre; start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    chk("R10 done reached (watchdog)", done, 1);
    chk("R10 no request after done", mdio_req, 0);
  endtask

  function automatic int entry(input int i);
    return phy_table[5*i +: 5];
  endfunction

  task automatic t_reset();
    chk("R10 reset done", done, 0);
    chk("R1 reset count", phy_count, 0);
    chk("R10 reset req", mdio_req, 0);
    chk("R9 reset warn", no_phy_warn, 0);
  endtask

  task automatic t_auto_scan();
    clear_model();
    m_st[3] = 16'h7849; m_ct[3] = 16'h0000; m_ad[3] = 16'h0000;
    m_st[0] = 16'h8001; m_ct[0] = 16'h1000; m_ad[0] = 16'h0061;
    m_st[7] = 16'h8201; m_st[12] = 16'h7A00;
    run_scan(0, 0, 0, 16'h0);
    chk("R1 count", phy_count, 2);
    chk("R1 entry0 addr3 first", entry(0), 3);
    chk("R1 entry1 addr0 last", entry(1), 0);
    chk("R1 all addresses probed", rd_st[31] + rd_st[0], 2);
    chk("R2 reject bit9 pattern", rd_ct[7] + rd_ct[12], 0);
    chk("R3 ctrl read of accepted", rd_ct[3], 1);
    chk("R4 built adv equals chosen, no write", wr_ad[3], 0);
    chk("R5 shared adv written to later phy", m_ad[0], 16'h01E1);
    chk("R6 auto sets enable+restart", m_ct[3], 16'h1200);
    chk("R8 double write on enable toggle", wr_ct[3], 2);
    chk("R8 gap >= GAP cycles", ct_gap[3] >= GAPC, 1);
    chk("R8 no write when unchanged", wr_ct[0], 0);
    chk("R9 no warn", no_phy_warn, 0);
  endtask

  task automatic t_forced_full();
    clear_model();
    foreach (m_st[a]) if (a == 1 || a == 2 || a == 5 || a == 9 || a == 20) m_st[a] = 16'h7800;
    m_ct[1] = 16'h1000; m_ad[1] = 16'h01E1;
    m_ct[2] = 16'h2100; m_ad[2] = 16'h0181;
    m_ct[5] = 16'h8C80; m_ad[5] = 16'h01E1;
    m_ct[9] = 16'h1000; m_ad[9] = 16'h01E1;
    run_scan(1, 1, 1, 16'h0181);
    chk("R1 table full count", phy_count, 4);
    chk("R1 entry3", entry(3), 9);
    chk("R1 early stop no probe of 10", rd_st[10], 0);
    chk("R1 early stop no probe of 20", rd_st[20], 0);
    chk("R5 preset written", m_ad[1], 16'h0181);
    chk("R5 no write when equal", wr_ad[2], 0);
    chk("R6 forced clears enable", m_ct[1], 16'h2100);
    chk("R8 forced toggle double write", wr_ct[9], 2);
    chk("R8 unchanged ctrl no write", wr_ct[2], 0);
    chk("R7 bits cleared then flags set", m_ct[5], 16'h2100);
    chk("R8 single write without toggle", wr_ct[5], 1);
  endtask

  task automatic t_slot_priority();
    clear_model();
    m_st[4] = 16'h7800; m_ct[4] = 16'h1000; m_ad[4] = 16'h01E1;
    m_st[6] = 16'h7800; m_ct[6] = 16'h1000; m_ad[6] = 16'h0000;
    run_scan(0, 0, 0, 16'h0);
    chk("R5 slot value beats read value", m_ad[4], 16'h0181);
    chk("R5 slot value beats built value", m_ad[6], 16'h0181);
    chk("R8 auto already enabled no write", wr_ct[4], 0);
    chk("R3 entries", entry(0) * 32 + entry(1), 4 * 32 + 6);
  endtask

  task automatic t_none();
    clear_model();
    run_scan(0, 0, 0, 16'h0);
    chk("R9 count zero", phy_count, 0);
    chk("R9 entry0 is 1", entry(0), 1);
    chk("R9 warn", no_phy_warn, 1);
    chk("R2 all-ones status rejected", rd_ct[1], 0);
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_auto_scan();
    t_forced_full();
    t_slot_priority();
    t_none();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule